// File: doc/BRIEF.md
# Dual-Rail Bipolar Line Monitor

This block watches a bipolar receive line delivered as two rails: one rail carries the positive marks and the other carries the negative marks. Both rails are sampled on the falling edge of the receive clock. The block merges them into a single NRZ stream and flags any mark whose polarity repeats the previous mark, which is a bipolar violation. The flag is registered in the same cycle as that bit on the NRZ output. It also raises a carrier-loss flag after a long run of empty bit times. The flag drops again only once the line has shown sustained ones density.

If the two rails are wired together, each mark arrives on both rails at once. The block treats such a bit as a plain mark and suspends the polarity check. The check resumes with the next mark that appears on one rail only, and that mark becomes the new polarity reference.

Top module: `bpv_line_monitor`

## Requirements
- R1: Both rails are sampled on the falling edge of clk_i. The output register that loads on the next rising edge drives nrz_o as the OR of the two sampled rails, so a rail change between the rising and falling edges is taken and a change after the falling edge is not.
- R2: A mark on one rail only, with the same polarity as the previous single-rail mark, sets bpv_o high in the same cycle that nrz_o carries that bit. Any zeros between the two marks are ignored.
- R3: bpv_o is low for zeros, for marks that alternate polarity, and for the first single-rail mark after reset or after a both-rails bit.
- R4: A bit with both rails high yields nrz_o high and bpv_o low and clears the polarity history. The next single-rail mark sets the new reference and is not flagged.
- R5: los_o rises in the output cycle of the 192nd consecutive bit with both rails low, and not in the cycle of the 191st.
- R6: Any mark before the 192nd zero restarts the zero run.
- R7: While los_o is high, a mark opens an 8-bit window, and back-to-back windows follow. los_o falls in the output cycle of the last bit of the 4th consecutive window that contains at least one mark.
- R8: A window without any mark discards the windows counted so far, and los_o stays high. Counting starts again with the next mark.
- R9: While rst_ni is low, nrz_o, bpv_o and los_o are low, and the zero run, the window progress and the polarity history are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pos_i | input | 1 | Positive-mark rail |
| neg_i | input | 1 | Negative-mark rail |
| nrz_o | output | 1 | Merged NRZ data |
| bpv_o | output | 1 | Violation flag, aligned to the offending bit on nrz_o |
| los_o | output | 1 | Carrier-loss flag |

## Verification
The hardest state to reach from the ports is a recovery from carrier loss that has been interrupted. This needs a run of 192 zeros, one window that counts, an empty window that discards it, and then four clean windows. The stimulus gets there with long directed zero runs and a loop that places one mark every 8 bits. The flag is sampled on the 31st bit of the recovery, where it must still be high, and on the 32nd, where it must be low. A separate directed case moves a rail between the two clock edges to show which edge takes the sample.

// File: rtl/bpv_pkg.sv
package bpv_pkg;
  typedef struct packed {
    logic pos;
    logic neg;
  } rail_t;

  function automatic logic is_mark(rail_t r);
    return r.pos | r.neg;
  endfunction

  function automatic logic is_single(rail_t r);
    return r.pos ^ r.neg;
  endfunction
endpackage

// File: rtl/bpv_rail_sampler.sv
module bpv_rail_sampler
  import bpv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pos_i,
  input  logic  neg_i,
  output rail_t rail_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rail_o <= '0;
    else begin
      rail_o.pos <= pos_i;
      rail_o.neg <= neg_i;
    end
  end
endmodule

// File: rtl/bpv_violation_detector.sv
module bpv_violation_detector
  import bpv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rail_t rail_i,
  output logic  nrz_o,
  output logic  bpv_o
);
  logic last_pos_q;
  logic pol_valid_q;
  logic bpv_d;

  assign bpv_d = is_single(rail_i) && pol_valid_q && (rail_i.pos == last_pos_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_pos_q  <= 1'b0;
      pol_valid_q <= 1'b0;
      nrz_o       <= 1'b0;
      bpv_o       <= 1'b0;
    end else begin
      nrz_o <= is_mark(rail_i);
      bpv_o <= bpv_d;
      // both rails high: tied rails, drop polarity reference
      if (rail_i.pos && rail_i.neg) begin
        pol_valid_q <= 1'b0;
      end else if (is_single(rail_i)) begin
        pol_valid_q <= 1'b1;
        last_pos_q  <= rail_i.pos;
      end
    end
  end
endmodule

// File: rtl/bpv_loss_detector.sv
module bpv_loss_detector #(
  parameter int unsigned ZERO_LIMIT = 192,
  parameter int unsigned WIN_BITS   = 8,
  parameter int unsigned WIN_NEED   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mark_i,
  output logic los_o
);
  localparam int unsigned ZW = $clog2(ZERO_LIMIT + 1);
  localparam int unsigned PW = (WIN_BITS > 2) ? $clog2(WIN_BITS) : 1;
  localparam int unsigned GW = (WIN_NEED > 2) ? $clog2(WIN_NEED) : 1;
  localparam logic [ZW-1:0] ZMAX  = ZW'(ZERO_LIMIT);
  localparam logic [ZW-1:0] ZTRIP = ZW'(ZERO_LIMIT - 1);
  localparam logic [PW-1:0] PLAST = PW'(WIN_BITS - 1);
  localparam logic [GW-1:0] GLAST = GW'(WIN_NEED - 1);

  logic [ZW-1:0] zcnt_q;
  logic [PW-1:0] ph_q;
  logic [GW-1:0] good_q;
  logic          armed_q;
  logic          seen_q;
  logic          seen_n;

  assign seen_n = seen_q | mark_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zcnt_q <= '0;
    else if (mark_i) zcnt_q <= '0;
    else if (zcnt_q != ZMAX) zcnt_q <= zcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      los_o   <= 1'b0;
      armed_q <= 1'b0;
      ph_q    <= '0;
      seen_q  <= 1'b0;
      good_q  <= '0;
    end else if (!los_o) begin
      armed_q <= 1'b0;
      ph_q    <= '0;
      seen_q  <= 1'b0;
      good_q  <= '0;
      if (!mark_i && zcnt_q >= ZTRIP) los_o <= 1'b1;
    end else if (!armed_q) begin
      // first window opens on a mark
      if (mark_i) begin
        armed_q <= 1'b1;
        ph_q    <= PW'(1);
        seen_q  <= 1'b1;
        good_q  <= '0;
      end
    end else if (ph_q == PLAST) begin
      ph_q   <= '0;
      seen_q <= 1'b0;
      if (seen_n) begin
        if (good_q == GLAST) begin
          los_o   <= 1'b0;
          armed_q <= 1'b0;
          good_q  <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end else begin
        armed_q <= 1'b0;
        good_q  <= '0;
      end
    end else begin
      ph_q   <= ph_q + 1'b1;
      seen_q <= seen_n;
    end
  end
endmodule

// File: rtl/bpv_line_monitor.sv
module bpv_line_monitor
  import bpv_pkg::*;
#(
  parameter int unsigned ZERO_LIMIT = 192,
  parameter int unsigned WIN_BITS   = 8,
  parameter int unsigned WIN_NEED   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  output logic nrz_o,
  output logic bpv_o,
  output logic los_o
);
  rail_t rail_s;

  bpv_rail_sampler u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pos_i  (pos_i),
    .neg_i  (neg_i),
    .rail_o (rail_s)
  );

  bpv_violation_detector u_viol (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rail_i (rail_s),
    .nrz_o  (nrz_o),
    .bpv_o  (bpv_o)
  );

  bpv_loss_detector #(
    .ZERO_LIMIT (ZERO_LIMIT),
    .WIN_BITS   (WIN_BITS),
    .WIN_NEED   (WIN_NEED)
  ) u_loss (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mark_i (is_mark(rail_s)),
    .los_o  (los_o)
  );
endmodule

// File: rtl/bpv_line_monitor_chk.sv
module bpv_line_monitor_chk #(
  parameter int unsigned ZERO_LIMIT = 192,
  parameter int unsigned WIN_BITS   = 8,
  parameter int unsigned WIN_NEED   = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic nrz_o,
  input logic bpv_o,
  input logic los_o
);
  localparam int unsigned ZW = $clog2(ZERO_LIMIT + 1);
  localparam int unsigned HOLD = WIN_BITS * WIN_NEED;
  localparam int unsigned HW = $clog2(HOLD + 1);

  logic [ZW-1:0] zrun_q;
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zrun_q <= '0;
    else if (nrz_o) zrun_q <= '0;
    else if (zrun_q != ZW'(ZERO_LIMIT)) zrun_q <= zrun_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_q <= '0;
    else if (!los_o) hi_q <= '0;
    else if (hi_q != HW'(HOLD)) hi_q <= hi_q + 1'b1;
  end

  assert_bpv_on_mark_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bpv_o |-> nrz_o);

  assert_los_after_run_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(los_o) |-> (!nrz_o && zrun_q >= ZW'(ZERO_LIMIT - 1)));

  assert_los_min_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(los_o) |-> (hi_q >= HW'(HOLD)));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R9: assert (!nrz_o && !bpv_o && !los_o);
    end
  end
endmodule

bind bpv_line_monitor bpv_line_monitor_chk #(
  .ZERO_LIMIT (ZERO_LIMIT),
  .WIN_BITS   (WIN_BITS),
  .WIN_NEED   (WIN_NEED)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .nrz_o  (nrz_o),
  .bpv_o  (bpv_o),
  .los_o  (los_o)
);

// File: tb/bpv_line_monitor_test.sv
`timescale 1ns/100ps
module bpv_line_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pos = 1'b0;
  logic neg = 1'b0;
  logic nrz, bpv, los;
  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bpv_line_monitor uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .pos_i  (pos),
    .neg_i  (neg),
    .nrz_o  (nrz),
    .bpv_o  (bpv),
    .los_o  (los)
  );

  // {pos, neg, exp_nrz, exp_bpv}
  localparam logic [3:0] VEC [16] = '{
    4'b1010, 4'b0110, 4'b0000, 4'b0111,
    4'b1010, 4'b1011, 4'b1110, 4'b0000,
    4'b1110, 4'b1010, 4'b1011, 4'b0110,
    4'b0000, 4'b0000, 4'b1010, 4'b1011
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // called at posedge+1; returns at posedge+1 with that bit on the outputs
  task automatic drive(input logic p, input logic n);
    pos = p;
    neg = n;
    @(posedge clk);
    #1;
  endtask

  task automatic zeros(input int cnt);
    for (int i = 0; i < cnt; i++) drive(1'b0, 1'b0);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset nrz", nrz, 1'b0);
    check("R9 reset bpv", bpv, 1'b0);
    check("R9 reset los", los, 1'b0);
    rst_n = 1'b1;

    // R2 R3 R4 vector walk
    for (int i = 0; i < 16; i++) begin
      drive(VEC[i][3], VEC[i][2]);
      check("R2/R3/R4 table nrz", nrz, VEC[i][1]);
      check("R2/R3/R4 table bpv", bpv, VEC[i][0]);
      check("R2/R3/R4 table los", los, 1'b0);
    end

    // R1: a rail change before the falling edge is taken
    pos = 1'b1; neg = 1'b0;
    #2;
    pos = 1'b0;
    @(posedge clk); #1;
    check("R1 sampled high at falling edge", nrz, 1'b1);
    pos = 1'b0; neg = 1'b0;
    #2;
    neg = 1'b1;
    @(posedge clk); #1;
    check("R1 sampled low at falling edge", nrz, 1'b0);

    // R6: a mark restarts the zero run
    zeros(150);
    drive(1'b0, 1'b1);
    zeros(191);
    check("R6 run restarted by mark", los, 1'b0);
    // R5: trips on the 192nd zero
    drive(1'b0, 1'b0);
    check("R5 los on 192nd zero", los, 1'b1);

    // R8: one good window, then an empty one
    drive(1'b1, 1'b0);
    zeros(7);
    zeros(8);
    check("R8 empty window keeps los", los, 1'b1);

    // R7: four windows with one mark each
    for (int w = 0; w < 4; w++) begin
      drive(w[0], ~w[0]);
      zeros(6);
      if (w == 3) check("R7 los held on 31st bit", los, 1'b1);
      drive(1'b0, 1'b0);
    end
    check("R7 los clears on 32nd bit", los, 1'b0);

    // R9: reset clears loss and polarity history
    drive(1'b1, 1'b0);
    zeros(192);
    check("R5 los set before reset", los, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R9 reset clears los", los, 1'b0);
    check("R9 reset clears nrz", nrz, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    drive(1'b1, 1'b0);
    check("R9 history cleared, nrz", nrz, 1'b1);
    check("R9 history cleared, no bpv", bpv, 1'b0);
    drive(1'b1, 1'b0);
    check("R2 repeat after reset flagged", bpv, 1'b1);

    summary();
  end
endmodule